// File: doc/BRIEF.md
# Leaky-Accumulator Converter Smoothing Filter

This block turns a noisy stream of converter readings into a steady, time-weighted average. It keeps one wide accumulator and no history buffer. The converter delivers each 12-bit result left-justified in a 15-bit word. The filter drops the three padding bits. On every accepted reading it removes one N-th of the accumulator and adds the new value. It then publishes the accumulator divided by N as the smoothed value.

After a step at the input, the output moves quickly at first and then settles slowly, because one reading can shift the total by only 1/N. The averaging length N is a run-time setting and may be any value from 1 to 255, so the block divides with a small sequential divider. It never relies on shifts. The block also emits a single-cycle start-conversion pulse at a fixed period, which is used to pace the external converter.

Samples enter over a valid/ready handshake. `in_ready` falls only while the one-entry holding register is full and the update engine has not yet taken its contents. A producer must then keep `in_valid` and `in_data` steady until `in_ready` returns. The smoothed output has no back-pressure: it is a register that changes only together with the one-cycle `avg_done` strobe.

Top module: `adc_leaky_smoother`

## Requirements
- R1: Only `in_data[14:3]` forms the 12-bit sample. The low three bits `in_data[2:0]` have no effect on any output.
- R2: For each accepted sample s, in order of acceptance, the accumulator becomes acc − floor(acc/N) + s.
- R3: After each update, `avg_out` becomes floor(acc/N) of the new accumulator, and `avg_done` is high for exactly one cycle in that same cycle. Between updates `avg_out` holds its value.
- R4: A pulse on `n_wr` loads `n_wdata` (8 bits) as the new N, which applies from the next update that starts. The value 0 behaves as 1, and N need not be a power of two (for example 80).
- R5: After reset the accumulator and `avg_out` are 0, N is 32, `avg_done` and `conv_start` are 0, and `in_ready` is 1.
- R6: The holding register has one entry. A sample accepted while an update is running is kept and processed later, never dropped or overwritten, so the number of `avg_done` strobes equals the number of accepted samples.
- R7: `conv_start` is a one-cycle pulse that is high after clock edges CONV_PERIOD, 2·CONV_PERIOD, … counted from reset release (default 2000).
- R8: With a constant input v, `avg_out` settles to within ±1 of v after enough updates (about 8·N).
- R9: The accumulator never exceeds 2^20 − 1 for any mix of samples and N, so the 32-bit accumulator cannot wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken this cycle |
| in_data | input | 15 | Left-justified converter result |
| n_wr | input | 1 | Load strobe for the averaging length |
| n_wdata | input | 8 | New averaging length (0 acts as 1) |
| avg_out | output | 32 | Registered smoothed value, truncated |
| avg_done | output | 1 | One-cycle strobe when `avg_out` is refreshed |
| conv_start | output | 1 | Periodic start-conversion pulse |

## Verification
Two events can fall in the same cycle. The first is a new sample arriving at the moment the engine takes the previous one out of the holding register. The second is an update completing on the same edge as the start-conversion pulse.

The bench provokes both by keeping `in_valid` high for long bursts, so that pushes and pops of the holding register coincide, and by running long enough that `avg_done` and `conv_start` overlap. On every clock it judges the outcome against a behavioural model. The model keeps a queue of accepted samples and an integer accumulator. No sample may be lost or reordered, and the timer may never be disturbed.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAK = 2'd1,
    ST_MEAN = 2'd2
  } lsm_state_e;

  // Averaging length as used by the divider: zero is promoted to one.
  function automatic logic [7:0] lsm_len_fix(input logic [7:0] raw);
    return (raw == 8'd0) ? 8'd1 : raw;
  endfunction

endpackage

// File: rtl/lsm_seq_div.sv
module lsm_seq_div #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W  = $clog2(DVD_W + 1);
  localparam int PROD_W = DVD_W + DVS_W;

  logic [DVD_W-1:0] quo_q, dvd_q;
  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  logic [DVS_W:0]   shifted, diff;
  logic             take_bit;
  logic [DVS_W-1:0] rem_nx;

  always_comb begin
    shifted  = {rem_q, quo_q[DVD_W-1]};
    diff     = shifted - {1'b0, dvs_q};
    take_bit = (shifted >= {1'b0, dvs_q});
    rem_nx   = take_bit ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        quo_q  <= dividend;
        dvd_q  <= dividend;
        dvs_q  <= divisor;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[DVD_W-2:0], take_bit};
        rem_q <= rem_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  logic [PROD_W-1:0] prod_lo, prod_hi, dvd_ext;
  always_comb begin
    dvd_ext = PROD_W'(dvd_q);
    prod_lo = PROD_W'(quo_q) * PROD_W'(dvs_q);
    prod_hi = prod_lo + PROD_W'(dvs_q);
  end

  // R2 R3: the quotient handed out is the exact truncated division
  a_r2_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (prod_lo <= dvd_ext) && (prod_hi > dvd_ext));

  // R4: a division is never started with a zero divisor
  a_r4_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |-> (divisor != '0));

endmodule

// File: rtl/lsm_conv_tick.sv
module lsm_conv_tick #(
  parameter int PERIOD = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      tick_q <= wrap;
    end
  end

  assign tick = tick_q;

  generate
    if (PERIOD > 1) begin : g_single
      // R7: the start pulse is one cycle wide
      a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/lsm_hold.sv
module lsm_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push) begin
      full_q <= 1'b1;
      data_q <= din;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign dout = data_q;

  // R6: a held sample stays put until the engine takes it
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop && !push) |=> (full_q && $stable(data_q)));

  // R6: never overwrite a sample that has not been taken
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full_q || pop));

endmodule

// File: rtl/adc_leaky_smoother.sv
module adc_leaky_smoother #(
  parameter int SAMPLE_W    = 15,
  parameter int RES_W       = 12,
  parameter int ACC_W       = 32,
  parameter int N_W         = 8,
  parameter int N_RESET     = 32,
  parameter int CONV_PERIOD = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                n_wr,
  input  logic [N_W-1:0]      n_wdata,
  output logic [ACC_W-1:0]    avg_out,
  output logic                avg_done,
  output logic                conv_start
);
  import lsm_pkg::*;

  localparam int SHIFT   = SAMPLE_W - RES_W;
  localparam int BOUND_W = N_W + RES_W;

  // Sample intake
  logic             push, pop, hold_full;
  logic [RES_W-1:0] sample_in, hold_data;
  lsm_state_e       state_q;

  assign sample_in = in_data[SAMPLE_W-1:SHIFT];
  assign pop       = (state_q == ST_IDLE) && hold_full;
  assign in_ready  = !hold_full || pop;
  assign push      = in_valid && in_ready;

  lsm_hold #(.W(RES_W)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (sample_in),
    .full  (hold_full),
    .dout  (hold_data)
  );

  // Averaging length register
  logic [N_W-1:0] n_reg_q, n_cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_reg_q <= N_W'(N_RESET);
    else if (n_wr) n_reg_q <= n_wdata;
  end

  // Update engine
  logic [ACC_W-1:0] acc_q, acc_nx, avg_q;
  logic [RES_W-1:0] s_cur_q;
  logic             avg_done_q;
  logic             div_start, div_busy, div_done;
  logic [ACC_W-1:0] div_dvd, div_quo;

  assign acc_nx = acc_q - div_quo + ACC_W'(s_cur_q);

  always_comb begin
    div_start = 1'b0;
    div_dvd   = acc_q;
    if (pop) begin
      div_start = 1'b1;
    end else if (state_q == ST_LEAK && div_done) begin
      div_start = 1'b1;
      div_dvd   = acc_nx;
    end
  end

  logic [N_W-1:0] div_dvs;
  assign div_dvs = pop ? lsm_len_fix(n_reg_q) : n_cur_q;

  lsm_seq_div #(.DVD_W(ACC_W), .DVS_W(N_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      acc_q      <= '0;
      avg_q      <= '0;
      s_cur_q    <= '0;
      n_cur_q    <= N_W'(1);
      avg_done_q <= 1'b0;
    end else begin
      avg_done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (pop) begin
            s_cur_q <= hold_data;
            n_cur_q <= lsm_len_fix(n_reg_q);
            state_q <= ST_LEAK;
          end
        end
        ST_LEAK: begin
          if (div_done) begin
            acc_q   <= acc_nx;
            state_q <= ST_MEAN;
          end
        end
        ST_MEAN: begin
          if (div_done) begin
            avg_q      <= div_quo;
            avg_done_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign avg_out  = avg_q;
  assign avg_done = avg_done_q;

  lsm_conv_tick #(.PERIOD(CONV_PERIOD)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (conv_start)
  );

  // R9: accumulator stays below 2^(N_W+RES_W)
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q >> BOUND_W) == '0);

  // R3: the refresh strobe is never two cycles long
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    avg_done_q |=> !avg_done_q);

  // R3: the output only moves together with the strobe
  a_r3_avg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_done_q |-> $stable(avg_q));

  // R4: the length in use is never zero once an update has begun
  a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (n_cur_q != '0));

  // R6: the engine never starts a division while one is running
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy);

endmodule

// File: tb/adc_leaky_smoother_tb_top.sv
module adc_leaky_smoother_tb_top;
  localparam int PERIOD = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [14:0] in_data = '0;
  logic        n_wr = 1'b0;
  logic [7:0]  n_wdata = '0;
  logic [31:0] avg_out;
  logic        avg_done;
  logic        conv_start;

  always #10 clk = ~clk;

  adc_leaky_smoother #(.CONV_PERIOD(PERIOD)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .n_wr       (n_wr),
    .n_wdata    (n_wdata),
    .avg_out    (avg_out),
    .avg_done   (avg_done),
    .conv_start (conv_start)
  );

  int     vectors = 0;
  int     fails = 0;
  int     q[$];
  longint acc_m = 0;
  longint n_m = 32;
  longint exp_avg = 0;
  longint edges = 0;
  int     dones = 0;
  int     accepted = 0;
  bit     prev_done = 1'b0;
  bit     finished = 1'b0;
  int     cyc = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst_n) edges++;
    cyc++;
  end

  // Watchdog
  always @(negedge clk) begin
    if (cyc > 195000 && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, 195000);
      summary();
    end
  end

  // Per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (avg_done) begin
        dones++;
        if (q.size() == 0) begin
          check(1'b0, "R6 strobe without sample", dones, accepted);
        end else begin
          longint s;
          s = q.pop_front();
          acc_m = acc_m - acc_m / n_m + s;   // R2
          exp_avg = acc_m / n_m;             // R3
        end
        check(!prev_done, "R3 strobe width", 2, 1);
      end
      prev_done = avg_done;
      check(avg_out == 32'(exp_avg), "R2 R3 avg", avg_out, exp_avg);
      check(conv_start == ((edges % PERIOD == 0) && edges > 0),
            "R7 conv_start", conv_start, (edges % PERIOD == 0) && edges > 0);
    end
  end

  task automatic stream(input int cnt, input int v, input int low);
    int sent = 0;
    @(negedge clk);
    while (sent < cnt) begin
      in_valid = 1'b1;
      in_data  = 15'((v << 3) | (low & 7));
      if (in_ready) begin
        q.push_back(v);
        accepted++;
        sent++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_len(input int len);
    drain();
    n_wr = 1'b1;
    n_wdata = 8'(len);
    @(negedge clk);
    n_wr = 1'b0;
    n_m = (len == 0) ? 1 : len;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check(avg_out == 0, "R5 avg_out", avg_out, 0);
    check(avg_done == 0, "R5 avg_done", avg_done, 0);
    check(in_ready == 1, "R5 in_ready", in_ready, 1);
    check(conv_start == 0, "R5 conv_start", conv_start, 0);
    rst_n = 1'b1;

    // R5: default length 32, R8: settles to a constant
    stream(300, 1000, 0);
    drain();
    check(avg_out >= 999 && avg_out <= 1001, "R8 settle N=32", avg_out, 1000);

    // R4: zero acts as one, R1: low bits ignored
    set_len(0);
    stream(1, 1234, 5);
    drain();
    check(avg_out == 1234, "R1 R4 N=0 low bits", avg_out, 1234);
    stream(1, 77, 7);
    drain();
    check(avg_out == 77, "R1 low bits", avg_out, 77);

    // R4: non power of two, step response, R8 settle
    set_len(80);
    stream(700, 3000, 3);
    drain();
    check(avg_out >= 2999 && avg_out <= 3001, "R8 settle N=80", avg_out, 3000);

    // R4: short length, step down
    set_len(8);
    stream(80, 17, 1);
    drain();
    check(avg_out >= 16 && avg_out <= 18, "R8 settle N=8", avg_out, 17);

    // R9: widest length at full scale, then collapse to one
    set_len(255);
    stream(150, 4095, 7);
    drain();
    check(avg_out <= 4095, "R9 no wrap", avg_out, 4095);
    set_len(1);
    stream(1, 2048, 0);
    drain();
    check(avg_out == 2048, "R9 R4 N=1", avg_out, 2048);

    // R6: nothing lost under back-pressure
    stream(40, 500, 2);
    drain();
    check(dones == accepted, "R6 count", dones, accepted);

    finished = 1'b1;
    summary();
  end

endmodule